// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block keeps the time of day and the calendar date in packed BCD registers: seconds, minutes, hours (24-hour), day of week, day of month, month, a two-digit year and a century flag. It is driven by a periodic `tick` enable. A configurable number of ticks makes one second, and an internal sub-second phase counts them. Each field rolls over into the next at its limit. The day-of-month limit follows the current month's length, and February gains a 29th day in leap years.

Leap years come from a divisible-by-four test applied directly to the BCD digits of the two-digit year. A separate century bit toggles each time the year wraps from 99 to 00. Together these give a correct calendar from 2000 through 2099. A host loads any single field through a select/data write port. All fields are visible at all times on the output ports.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the fields are 00:00:00, day of week 0, day 01, month 01, year 00, century 0, and the sub-second phase is 0.
- R2: Seconds advance by one on every TICKS_PER_SEC-th `tick` pulse. No field changes in a cycle with neither `tick` nor `wr_en`.
- R3: Seconds and minutes wrap from 59 to 00, and hours wrap from 23 to 00. Each wrap carries one increment into the next field.
- R4: Day of month wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in months 01, 03, 05, 07, 08, 10 and 12. The month then advances.
- R5: In February the day wraps after 29 in a leap year and after 28 otherwise. A year is a leap year when its tens digit is even and its units digit is 0, 4 or 8, or when its tens digit is odd and its units digit is 2 or 6.
- R6: Month wraps from 12 to 01 and advances the year. The year wraps from 99 to 00 and toggles the century bit.
- R7: Day of week counts 0 to 6, wraps to 0, and advances once on each hour rollover from 23 to 00.
- R8: When `wr_en` is high, the field chosen by `wr_sel` loads `wr_data` verbatim on the next edge. This takes priority over an increment in the same cycle and blocks that field's carry. The `wr_sel` codes are 0 seconds, 1 minutes, 2 hours, 3 day of week (bits 2:0), 4 day of month, 5 month, 6 year, 7 century (bit 0).
- R9: A write to the seconds field clears the sub-second phase. The next seconds increment then needs a full TICKS_PER_SEC ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sub-second time base enable |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 3 | Field select for the write |
| wr_data | input | 8 | BCD value to load |
| sec | output | 8 | Seconds, BCD 00-59 |
| min | output | 8 | Minutes, BCD 00-59 |
| hour | output | 8 | Hours, BCD 00-23 |
| wday | output | 3 | Day of week 0-6 |
| mday | output | 8 | Day of month, BCD 01-31 |
| month | output | 8 | Month, BCD 01-12 |
| year | output | 8 | Two-digit year, BCD 00-99 |
| century | output | 1 | Century flag |

## Verification
The counter is started just before the end of every month length: 30-day months, 31-day months, and February in leap years with even and odd tens digits (00, 12, 24) and in non-leap years (10, 23). Each start shows whether the digit-based leap test and the month table pick the right last day. A December 31 start in year 99 separates a correct century toggle from a plain year wrap. Writes that land in the same cycle as a seconds or minutes carry show whether write priority and carry suppression work. A seconds write made midway through a second, followed by a count of ticks, shows whether the phase is cleared. Long runs with ticks every cycle and with sparse ticks check the whole chain against the reference model cycle by cycle.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int BCD_W   = 8;
    localparam int WDAY_W  = 3;
    localparam int SEL_W   = 3;
    localparam int NUM_BCD = 6;

    typedef enum logic [SEL_W-1:0] {
        SEL_SEC   = 3'd0,
        SEL_MIN   = 3'd1,
        SEL_HOUR  = 3'd2,
        SEL_WDAY  = 3'd3,
        SEL_MDAY  = 3'd4,
        SEL_MONTH = 3'd5,
        SEL_YEAR  = 3'd6,
        SEL_CENT  = 3'd7
    } field_sel_e;

    typedef struct packed {
        logic [BCD_W-1:0]  sec;
        logic [BCD_W-1:0]  min;
        logic [BCD_W-1:0]  hour;
        logic [WDAY_W-1:0] wday;
        logic [BCD_W-1:0]  mday;
        logic [BCD_W-1:0]  month;
        logic [BCD_W-1:0]  year;
        logic              cent;
    } cal_t;

    localparam cal_t CAL_RESET = '{
        sec: 8'h00, min: 8'h00, hour: 8'h00, wday: 3'd0,
        mday: 8'h01, month: 8'h01, year: 8'h00, cent: 1'b0
    };

    localparam logic [WDAY_W-1:0] WDAY_LAST = 3'd6;

    // chain position -> write select code
    function automatic field_sel_e chain_sel(input int idx);
        case (idx)
            0:       return SEL_SEC;
            1:       return SEL_MIN;
            2:       return SEL_HOUR;
            3:       return SEL_MDAY;
            4:       return SEL_MONTH;
            default: return SEL_YEAR;
        endcase
    endfunction

    // fixed upper limit per chain position (day of month is dynamic)
    function automatic logic [BCD_W-1:0] chain_lim(input int idx);
        case (idx)
            0, 1:    return 8'h59;
            2:       return 8'h23;
            4:       return 8'h12;
            default: return 8'h99;
        endcase
    endfunction

    function automatic logic [BCD_W-1:0] chain_base(input int idx);
        return (idx == 3 || idx == 4) ? 8'h01 : 8'h00;
    endfunction

endpackage

// File: rtl/rtc_bcd_step.sv
module rtc_bcd_step
    import rtc_cal_pkg::*;
(
    input  logic [BCD_W-1:0] cur,
    input  logic [BCD_W-1:0] lim,
    input  logic [BCD_W-1:0] base,
    output logic [BCD_W-1:0] nxt,
    output logic             at_lim
);
    logic [3:0] units;
    logic [3:0] tens;

    assign units = cur[3:0];
    assign tens  = cur[BCD_W-1:4];

    always_comb begin
        // ordering of valid BCD matches binary ordering
        at_lim = (cur >= lim);
        if (at_lim) begin
            nxt = base;
        end else if (units >= 4'd9) begin
            nxt = {tens + 4'd1, 4'd0};
        end else begin
            nxt = {tens, units + 4'd1};
        end
    end
endmodule

// File: rtl/rtc_month_days.sv
module rtc_month_days
    import rtc_cal_pkg::*;
(
    input  logic [BCD_W-1:0] month,
    input  logic [BCD_W-1:0] year,
    output logic             leap,
    output logic [BCD_W-1:0] last_day
);
    logic       tens_odd;
    logic [3:0] units;

    assign tens_odd = year[4];
    assign units    = year[3:0];

    always_comb begin
        if (tens_odd) begin
            leap = (units == 4'd2) || (units == 4'd6);
        end else begin
            leap = (units == 4'd0) || (units == 4'd4) || (units == 4'd8);
        end

        case (month)
            8'h02:                      last_day = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
            default:                    last_day = 8'h31;
        endcase
    end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_cal_pkg::*;
#(
    parameter int TICKS_PER_SEC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BCD_W-1:0]  wr_data,
    output logic [BCD_W-1:0]  sec,
    output logic [BCD_W-1:0]  min,
    output logic [BCD_W-1:0]  hour,
    output logic [WDAY_W-1:0] wday,
    output logic [BCD_W-1:0]  mday,
    output logic [BCD_W-1:0]  month,
    output logic [BCD_W-1:0]  year,
    output logic              century
);
    localparam int              PH_W    = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(TICKS_PER_SEC - 1);

    cal_t            st_q, st_d;
    logic [PH_W-1:0] phase_q, phase_d;

    logic [BCD_W-1:0] cur   [NUM_BCD];
    logic [BCD_W-1:0] lim   [NUM_BCD];
    logic [BCD_W-1:0] base  [NUM_BCD];
    logic [BCD_W-1:0] nxt   [NUM_BCD];
    logic [BCD_W-1:0] val   [NUM_BCD];
    logic [NUM_BCD-1:0] at_lim;
    logic [NUM_BCD-1:0] hit;
    logic [NUM_BCD:0]   carry;

    logic             sec_tick;
    logic             day_adv;
    logic             year_wrap;
    logic             leap;
    logic [BCD_W-1:0] last_day;

    assign cur[0] = st_q.sec;
    assign cur[1] = st_q.min;
    assign cur[2] = st_q.hour;
    assign cur[3] = st_q.mday;
    assign cur[4] = st_q.month;
    assign cur[5] = st_q.year;

    rtc_month_days u_mdays (
        .month    (st_q.month),
        .year     (st_q.year),
        .leap     (leap),
        .last_day (last_day)
    );

    for (genvar gi = 0; gi < NUM_BCD; gi++) begin : g_chain
        if (gi == 3) begin : g_dyn
            assign lim[gi] = last_day;
        end else begin : g_fix
            assign lim[gi] = chain_lim(gi);
        end
        assign base[gi] = chain_base(gi);

        rtc_bcd_step u_step (
            .cur    (cur[gi]),
            .lim    (lim[gi]),
            .base   (base[gi]),
            .nxt    (nxt[gi]),
            .at_lim (at_lim[gi])
        );
    end

    always_comb begin
        st_d    = st_q;
        phase_d = phase_q;

        sec_tick = tick && (phase_q == PH_LAST);

        if (wr_en && (wr_sel == SEL_SEC)) begin
            phase_d = '0;
        end else if (tick) begin
            phase_d = sec_tick ? '0 : phase_q + 1'b1;
        end

        carry[0] = sec_tick;
        for (int i = 0; i < NUM_BCD; i++) begin
            hit[i]     = wr_en && (wr_sel == chain_sel(i));
            carry[i+1] = carry[i] && at_lim[i] && !hit[i];
            if (hit[i]) begin
                val[i] = wr_data;
            end else if (carry[i]) begin
                val[i] = nxt[i];
            end else begin
                val[i] = cur[i];
            end
        end

        day_adv   = carry[3];
        year_wrap = carry[NUM_BCD];

        st_d.sec   = val[0];
        st_d.min   = val[1];
        st_d.hour  = val[2];
        st_d.mday  = val[3];
        st_d.month = val[4];
        st_d.year  = val[5];

        if (wr_en && (wr_sel == SEL_WDAY)) begin
            st_d.wday = wr_data[WDAY_W-1:0];
        end else if (day_adv) begin
            st_d.wday = (st_q.wday >= WDAY_LAST) ? '0 : st_q.wday + 1'b1;
        end

        if (wr_en && (wr_sel == SEL_CENT)) begin
            st_d.cent = wr_data[0];
        end else if (year_wrap) begin
            st_d.cent = !st_q.cent;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= CAL_RESET;
            phase_q <= '0;
        end else begin
            st_q    <= st_d;
            phase_q <= phase_d;
        end
    end

    assign sec     = st_q.sec;
    assign min     = st_q.min;
    assign hour    = st_q.hour;
    assign wday    = st_q.wday;
    assign mday    = st_q.mday;
    assign month   = st_q.month;
    assign year    = st_q.year;
    assign century = st_q.cent;

    // R2: idle cycles leave every field untouched
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_en) |=> $stable(st_q));

    // R3: seconds roll from 59 to 00 and minutes move
    a_r3_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && sec_tick && st_q.sec == 8'h59) |=> (st_q.sec == 8'h00 && st_q.min != $past(st_q.min)));

    // R4: April ends after its 30th day
    a_r4_april_end: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && day_adv && st_q.month == 8'h04 && st_q.mday == 8'h30) |=> (st_q.mday == 8'h01 && st_q.month == 8'h05));

    // R5: leap February reaches its 29th day
    a_r5_leap_feb: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && day_adv && leap && st_q.month == 8'h02 && st_q.mday == 8'h28) |=> (st_q.mday == 8'h29));

    // R6: year wrap toggles the century flag
    a_r6_century_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && year_wrap) |=> (st_q.cent != $past(st_q.cent) && st_q.year == 8'h00));

    // R7: day of week returns to 0 after 6
    a_r7_wday_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && day_adv && st_q.wday == WDAY_LAST) |=> (st_q.wday == 3'd0));

    // R8: a seconds write wins over the increment
    a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_SEC) |=> (st_q.sec == $past(wr_data) && $stable(st_q.min)));

    // R9: a seconds write restarts the sub-second phase
    a_r9_phase_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_SEC) |=> (phase_q == '0));

endmodule

// File: tb/rtc_calendar_test.sv
module rtc_calendar_test;
    localparam int TPS = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] sec, min, hour, mday, month, year;
    logic [2:0] wday;
    logic       century;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    string tag = "R1";

    // reference model state, plain integers
    int m_ph, m_s, m_mi, m_h, m_wd, m_d, m_mo, m_y, m_c;

    rtc_calendar #(.TICKS_PER_SEC(TPS)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .sec(sec), .min(min), .hour(hour), .wday(wday),
        .mday(mday), .month(month), .year(year), .century(century)
    );

    always #5 clk = ~clk;

    function automatic logic [7:0] to_bcd(int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int from_bcd(logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic int days_in(int mo, int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic model_reset();
        m_ph = 0; m_s = 0; m_mi = 0; m_h = 0; m_wd = 0;
        m_d = 1; m_mo = 1; m_y = 0; m_c = 0;
    endtask

    task automatic model_clock(bit tk, bit we, int sel, logic [7:0] dat);
        bit c;
        int last;
        int v;
        last = days_in(m_mo, m_y);
        v = from_bcd(dat);
        c = tk && (m_ph == TPS - 1);
        if (we && sel == 0) m_ph = 0;
        else if (tk) m_ph = (m_ph == TPS - 1) ? 0 : m_ph + 1;

        if (we && sel == 0) begin m_s = v; c = 0; end
        else if (c) begin if (m_s >= 59) m_s = 0; else begin m_s++; c = 0; end end
        if (we && sel == 1) begin m_mi = v; c = 0; end
        else if (c) begin if (m_mi >= 59) m_mi = 0; else begin m_mi++; c = 0; end end
        if (we && sel == 2) begin m_h = v; c = 0; end
        else if (c) begin if (m_h >= 23) m_h = 0; else begin m_h++; c = 0; end end
        if (we && sel == 3) m_wd = int'(dat[2:0]);
        else if (c) m_wd = (m_wd >= 6) ? 0 : m_wd + 1;
        if (we && sel == 4) begin m_d = v; c = 0; end
        else if (c) begin if (m_d >= last) m_d = 1; else begin m_d++; c = 0; end end
        if (we && sel == 5) begin m_mo = v; c = 0; end
        else if (c) begin if (m_mo >= 12) m_mo = 1; else begin m_mo++; c = 0; end end
        if (we && sel == 6) begin m_y = v; c = 0; end
        else if (c) begin if (m_y >= 99) m_y = 0; else begin m_y++; c = 0; end end
        if (we && sel == 7) m_c = int'(dat[0]);
        else if (c) m_c = 1 - m_c;
    endtask

    task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    task automatic compare_all();
        check(tag, "sec", sec, to_bcd(m_s));
        check(tag, "min", min, to_bcd(m_mi));
        check(tag, "hour", hour, to_bcd(m_h));
        check(tag, "wday", {5'd0, wday}, 8'(m_wd));
        check(tag, "mday", mday, to_bcd(m_d));
        check(tag, "month", month, to_bcd(m_mo));
        check(tag, "year", year, to_bcd(m_y));
        check(tag, "century", {7'd0, century}, 8'(m_c));
    endtask

    task automatic step(bit tk, bit we, int sel, logic [7:0] dat);
        tick = tk; wr_en = we; wr_sel = 3'(sel); wr_data = dat;
        @(posedge clk);
        model_clock(tk, we, sel, dat);
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        compare_all();
    endtask

    task automatic set_all(logic [7:0] h, logic [7:0] mi, logic [7:0] s,
                           logic [7:0] d, logic [7:0] mo, logic [7:0] y, int wd, int cen);
        step(0, 1, 2, h);
        step(0, 1, 1, mi);
        step(0, 1, 4, d);
        step(0, 1, 5, mo);
        step(0, 1, 6, y);
        step(0, 1, 3, 8'(wd));
        step(0, 1, 7, 8'(cen));
        step(0, 1, 0, s);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) step(1, 0, 0, 8'h00);
    endtask

    // start at 23:59:59 on a given day, then roll into the next day
    task automatic roll_day(logic [7:0] d, logic [7:0] mo, logic [7:0] y,
                            logic [7:0] ed, logic [7:0] emo, string req);
        tag = req;
        set_all(8'h23, 8'h59, 8'h59, d, mo, y, 2, 0);
        ticks(TPS);
        check(req, "day after rollover", mday, ed);
        check(req, "month after rollover", month, emo);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL R2 watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        tag = "R1";
        compare_all();
        rst_n = 1'b1;
        @(negedge clk);
        compare_all();

        // R2: idle, then counting
        tag = "R2";
        for (int i = 0; i < 5; i++) step(0, 0, 0, 8'h00);
        ticks(3);
        check("R2", "sec before fourth tick", sec, 8'h00);
        ticks(1);
        check("R2", "sec after four ticks", sec, 8'h01);
        for (int i = 0; i < 40; i++) step(i % 3 == 0, 0, 0, 8'h00);

        // R3 and R7: full time-of-day rollover with weekday wrap
        tag = "R3";
        set_all(8'h23, 8'h59, 8'h58, 8'h10, 8'h03, 8'h21, 6, 0);
        ticks(2 * TPS);
        check("R3", "hour wraps", hour, 8'h00);
        check("R3", "minute wraps", min, 8'h00);
        check("R7", "weekday wraps to 0", {5'd0, wday}, 8'h00);
        check("R7", "day advances", mday, 8'h11);

        // R4: month lengths
        roll_day(8'h30, 8'h04, 8'h21, 8'h01, 8'h05, "R4");
        roll_day(8'h30, 8'h11, 8'h21, 8'h01, 8'h12, "R4");
        roll_day(8'h30, 8'h01, 8'h21, 8'h31, 8'h01, "R4");
        roll_day(8'h31, 8'h08, 8'h21, 8'h01, 8'h09, "R4");

        // R5: leap rule on BCD digits
        roll_day(8'h28, 8'h02, 8'h24, 8'h29, 8'h02, "R5");
        roll_day(8'h29, 8'h02, 8'h24, 8'h01, 8'h03, "R5");
        roll_day(8'h28, 8'h02, 8'h23, 8'h01, 8'h03, "R5");
        roll_day(8'h28, 8'h02, 8'h00, 8'h29, 8'h02, "R5");
        roll_day(8'h28, 8'h02, 8'h12, 8'h29, 8'h02, "R5");
        roll_day(8'h28, 8'h02, 8'h10, 8'h01, 8'h03, "R5");

        // R6: year end and century toggle
        tag = "R6";
        set_all(8'h23, 8'h59, 8'h59, 8'h31, 8'h12, 8'h99, 1, 0);
        ticks(TPS);
        check("R6", "year wraps", year, 8'h00);
        check("R6", "month wraps", month, 8'h01);
        check("R6", "century toggles", {7'd0, century}, 8'h01);
        set_all(8'h23, 8'h59, 8'h59, 8'h31, 8'h12, 8'h98, 1, 1);
        ticks(TPS);
        check("R6", "plain year step keeps century", {7'd0, century}, 8'h01);
        check("R6", "year advances", year, 8'h99);

        // R8: write collides with a seconds carry
        tag = "R8";
        set_all(8'h10, 8'h20, 8'h59, 8'h05, 8'h06, 8'h30, 3, 0);
        ticks(TPS - 1);
        step(1, 1, 1, 8'h42);
        check("R8", "minute write wins", min, 8'h42);
        check("R8", "seconds still wrap", sec, 8'h00);
        check("R8", "hour untouched", hour, 8'h10);
        set_all(8'h10, 8'h59, 8'h59, 8'h05, 8'h06, 8'h30, 3, 0);
        ticks(TPS - 1);
        step(1, 1, 0, 8'h59);
        check("R8", "seconds write blocks carry", min, 8'h59);

        // R9: seconds write mid-second resets the phase
        tag = "R9";
        set_all(8'h01, 8'h02, 8'h03, 8'h05, 8'h06, 8'h30, 3, 0);
        ticks(2);
        step(0, 1, 0, 8'h20);
        ticks(TPS - 1);
        check("R9", "no increment before full second", sec, 8'h20);
        ticks(1);
        check("R9", "increment after full second", sec, 8'h21);

        // long runs against the model
        tag = "R2";
        set_all(8'h22, 8'h58, 8'h00, 8'h31, 8'h12, 8'h99, 5, 1);
        for (int i = 0; i < 12000; i++) step(1, 0, 0, 8'h00);
        for (int i = 0; i < 3000; i++) step((i % 5) != 2, 0, 0, 8'h00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule